// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block guards the mode transitions of an embedded flash array. A CPU-side register interface writes a control register that holds a write-enable bit, a program-request bit and an erase-request bit. It also writes a set of erase-block select registers, with one bit per block. The block drives program-active, erase-active and a per-block erase mask toward the flash sequencer. Three layers of protection sit in front of those outputs. Hardware protection comes from reset and standby. Software protection comes from the write-enable bit and from the block selection. Error protection comes from a sticky error flag.

The error flag is set when one of the following CPU-side events arrives while a program or erase is running: a read of the flash address range, entry into exception handling, entry into sleep, or a bus grant to the DMA controller. Once the flag is set, the active operation stops in the same cycle. Both modes stay locked out until reset or standby. The cell timing and the verify sequences belong to the sequencer and are not part of this block.

Top module: `flash_guard`

## Requirements
- R1: After an asynchronous reset (rstN low), program-active, erase-active, the erase mask and the error flag are 0, and every register address reads 0x00.
- R2: Register map. Address 0 is control: bit 0 is write-enable, bit 1 is program request, bit 2 is erase request, and the other bits read 0. Address 1 is status: bit 7 is the error flag, and the other bits read 0. Address 2 is the block-select register for blocks 7..0. Address 3 is the block-select register for blocks 15..8. Reads are combinational from the address.
- R3: When write-enable=1, program request=1, erase request=0 and the error flag is 0, progActive is 1 from the clock edge that captures the control write.
- R4: While write-enable is 0, no request bit can raise progActive or eraseActive. Clearing write-enable drops an active mode at the edge that captures the write.
- R5: eraseActive needs write-enable=1, erase request=1, program request=0, no error, and at least one block-select bit set. If both block registers are 0x00, no erase starts. eraseMask equals {blkHi, blkLo} ANDed with eraseActive.
- R6: If the program request and the erase request are both 1, neither mode is active.
- R7: A flash read, an exception entry, a sleep entry or a DMA bus grant that is sampled while a mode is active sets the error flag at that edge. Both modes are 0 from that edge on.
- R8: The same four events, sampled while no mode is active, leave the error flag at 0.
- R9: The error flag is sticky. Writes to the status address do not clear it, and rewriting the control register does not restore a mode while it is set.
- R10: While standby is 1, progActive, eraseActive and eraseMask are 0 at once, and register writes are ignored. At the next edge the error flag, the control register and both block registers are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Standby level; aborts and clears |
| wrEn | input | 1 | Single-cycle register write strobe |
| regAddr | input | 2 | Register select |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for regAddr |
| flashRead | input | 1 | CPU read of the flash address range |
| excEntry | input | 1 | Exception-handling entry pulse (not reset) |
| sleepEntry | input | 1 | Sleep-entry pulse |
| dmaGrant | input | 1 | Bus mastership granted to DMA |
| progActive | output | 1 | Program mode active |
| eraseActive | output | 1 | Erase mode active |
| eraseMask | output | 16 | Per-block erase enable toward the sequencer |
| errFlag | output | 1 | Sticky error-protection flag |

## Verification
The mode outputs are driven with control values that separate the three gates. Write-enable alone, program alone, erase alone, and both requests together show whether the write-enable gate and the exclusion rule are decoded independently. Erase is tried with empty, single-register and two-register block selections, which separates the all-zero inhibit from the mask wiring. Each of the four error events is fired once during an active program or erase and once while idle, which shows that every source is gated by activity rather than merely ORed into the flag. Standby pulses issued during an error, and with writes held against them, show the difference between an immediate abort and the clear that follows at the next edge.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  // register addresses (block registers start at BLK_BASE)
  localparam int CTRL_ADDR = 0;
  localparam int STAT_ADDR = 1;
  localparam int BLK_BASE  = 2;

  // control register bit positions
  localparam int SWE_BIT   = 0;
  localparam int PROG_BIT  = 1;
  localparam int ERASE_BIT = 2;

  // status register bit position of the error flag
  localparam int ERR_BIT   = 7;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_PROG   = 2'd1,
    MODE_ERASE  = 2'd2,
    MODE_LOCKED = 2'd3
  } guardMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic wrCtrl;
    logic wrBlk;
  } regStrobe_t;

endpackage

// File: rtl/flash_guard_regs.sv
module flash_guard_regs
  import flash_guard_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BLK_REGS = 2,
  parameter int ADDR_W   = 2,
  localparam int NUM_BLOCKS = DATA_W * BLK_REGS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strb,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  eraseActive,
  input  logic                  errFlag,
  output logic                  swe,
  output logic                  progBit,
  output logic                  eraseBit,
  output logic [NUM_BLOCKS-1:0] blkAll,
  output logic [DATA_W-1:0]     rdData,
  output logic [NUM_BLOCKS-1:0] eraseMask
);

  logic [2:0] ctrlReg;
  logic [BLK_REGS-1:0][DATA_W-1:0] blkReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ctrlReg <= '0;
    else if (strb.clear)   ctrlReg <= '0;
    else if (strb.wrCtrl)  ctrlReg <= {wrData[ERASE_BIT], wrData[PROG_BIT], wrData[SWE_BIT]};
  end

  generate
    for (genvar g = 0; g < BLK_REGS; g++) begin : gBlk
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           blkReg[g] <= '0;
        else if (strb.clear) blkReg[g] <= '0;
        else if (strb.wrBlk && (int'(regAddr) == BLK_BASE + g))
          blkReg[g] <= wrData;
      end
    end
  endgenerate

  assign swe      = ctrlReg[0];
  assign progBit  = ctrlReg[1];
  assign eraseBit = ctrlReg[2];
  assign blkAll   = blkReg;

  always_comb begin
    rdData = '0;
    if (int'(regAddr) == CTRL_ADDR) begin
      rdData[SWE_BIT]   = ctrlReg[0];
      rdData[PROG_BIT]  = ctrlReg[1];
      rdData[ERASE_BIT] = ctrlReg[2];
    end else if (int'(regAddr) == STAT_ADDR) begin
      rdData[ERR_BIT] = errFlag;
    end
    for (int g = 0; g < BLK_REGS; g++) begin
      if (int'(regAddr) == BLK_BASE + g) rdData = blkReg[g];
    end
  end

  assign eraseMask = blkAll & {NUM_BLOCKS{eraseActive}};

endmodule

// File: rtl/flash_guard_ctrl.sv
module flash_guard_ctrl
  import flash_guard_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int BLK_REGS   = 2,
  parameter int ADDR_W     = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  standby,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  swe,
  input  logic                  progBit,
  input  logic                  eraseBit,
  input  logic [NUM_BLOCKS-1:0] blkAll,
  input  logic                  flashRead,
  input  logic                  excEntry,
  input  logic                  sleepEntry,
  input  logic                  dmaGrant,
  output regStrobe_t            strb,
  output logic                  progActive,
  output logic                  eraseActive,
  output logic                  errFlag
);

  guardMode_t mode;
  logic anyEvent;
  logic opRunning;

  // write decode; standby blocks every write and forces a clear
  always_comb begin
    strb.clear  = standby;
    strb.wrCtrl = wrEn && !standby && (int'(regAddr) == CTRL_ADDR);
    strb.wrBlk  = wrEn && !standby && (int'(regAddr) >= BLK_BASE)
                  && (int'(regAddr) < BLK_BASE + BLK_REGS);
  end

  // mode selection: hardware, error, then software protection
  always_comb begin
    if (standby)                              mode = MODE_IDLE;
    else if (errFlag)                         mode = MODE_LOCKED;
    else if (!swe)                            mode = MODE_IDLE;
    else if (progBit && !eraseBit)            mode = MODE_PROG;
    else if (eraseBit && !progBit && |blkAll) mode = MODE_ERASE;
    else                                      mode = MODE_IDLE;
  end

  assign progActive  = (mode == MODE_PROG);
  assign eraseActive = (mode == MODE_ERASE);
  assign opRunning   = progActive || eraseActive;
  assign anyEvent    = flashRead || excEntry || sleepEntry || dmaGrant;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        errFlag <= 1'b0;
    else if (standby)                 errFlag <= 1'b0;
    else if (anyEvent && opRunning)   errFlag <= 1'b1;
  end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BLK_REGS = 2,
  localparam int NUM_BLOCKS = DATA_W * BLK_REGS,
  localparam int ADDR_W     = $clog2(BLK_BASE + BLK_REGS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  standby,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  input  logic                  flashRead,
  input  logic                  excEntry,
  input  logic                  sleepEntry,
  input  logic                  dmaGrant,
  output logic                  progActive,
  output logic                  eraseActive,
  output logic [NUM_BLOCKS-1:0] eraseMask,
  output logic                  errFlag
);

  regStrobe_t strb;
  logic swe, progBit, eraseBit;
  logic [NUM_BLOCKS-1:0] blkAll;

  flash_guard_ctrl #(
    .NUM_BLOCKS(NUM_BLOCKS), .BLK_REGS(BLK_REGS), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .standby(standby), .wrEn(wrEn), .regAddr(regAddr),
    .swe(swe), .progBit(progBit), .eraseBit(eraseBit), .blkAll(blkAll),
    .flashRead(flashRead), .excEntry(excEntry), .sleepEntry(sleepEntry),
    .dmaGrant(dmaGrant), .strb(strb), .progActive(progActive),
    .eraseActive(eraseActive), .errFlag(errFlag)
  );

  flash_guard_regs #(
    .DATA_W(DATA_W), .BLK_REGS(BLK_REGS), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr), .wrData(wrData),
    .eraseActive(eraseActive), .errFlag(errFlag), .swe(swe), .progBit(progBit),
    .eraseBit(eraseBit), .blkAll(blkAll), .rdData(rdData), .eraseMask(eraseMask)
  );

endmodule

// File: rtl/flash_guard_checker.sv
module flash_guard_checker #(
  parameter int NUM_BLOCKS = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  standby,
  input logic                  flashRead,
  input logic                  excEntry,
  input logic                  sleepEntry,
  input logic                  dmaGrant,
  input logic                  progActive,
  input logic                  eraseActive,
  input logic [NUM_BLOCKS-1:0] eraseMask,
  input logic                  errFlag
);

  logic evt;
  assign evt = flashRead || excEntry || sleepEntry || dmaGrant;

  p_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(progActive && eraseActive));

  p_mask_active_r5: assert property (@(posedge clk) disable iff (!rstN)
    (eraseMask != '0) |-> eraseActive);

  p_erase_has_block_r5: assert property (@(posedge clk) disable iff (!rstN)
    eraseActive |-> (eraseMask != '0));

  p_event_sets_err_r7: assert property (@(posedge clk) disable iff (!rstN)
    (evt && (progActive || eraseActive) && !standby) |=> errFlag);

  p_locked_no_mode_r7: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (!progActive && !eraseActive));

  p_idle_no_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!errFlag && !progActive && !eraseActive) |=> !errFlag);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !standby) |=> errFlag);

  p_standby_abort_r10: assert property (@(posedge clk) disable iff (!rstN)
    standby |-> (!progActive && !eraseActive && eraseMask == '0));

  p_standby_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> !errFlag);

endmodule

bind flash_guard flash_guard_checker #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
  .clk(clk), .rstN(rstN), .standby(standby), .flashRead(flashRead),
  .excEntry(excEntry), .sleepEntry(sleepEntry), .dmaGrant(dmaGrant),
  .progActive(progActive), .eraseActive(eraseActive), .eraseMask(eraseMask),
  .errFlag(errFlag)
);

// File: tb/flash_guard_test.sv
module flash_guard_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic standby = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic flashRead = 1'b0, excEntry = 1'b0, sleepEntry = 1'b0, dmaGrant = 1'b0;
  logic progActive, eraseActive, errFlag;
  logic [15:0] eraseMask;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  flash_guard uut (
    .clk(clk), .rstN(rstN), .standby(standby), .wrEn(wrEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .flashRead(flashRead), .excEntry(excEntry),
    .sleepEntry(sleepEntry), .dmaGrant(dmaGrant), .progActive(progActive),
    .eraseActive(eraseActive), .eraseMask(eraseMask), .errFlag(errFlag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = rdData;
  endtask

  task automatic pulseStandby();
    @(negedge clk);
    standby = 1'b1;
    #1;
    chk("R10 standby abort prog", progActive, 0);
    chk("R10 standby abort erase", eraseActive, 0);
    chk("R10 standby mask", eraseMask, 0);
    @(negedge clk);
    standby = 1'b0;
    #1;
  endtask

  task automatic fireEvent(input int which);
    @(negedge clk);
    case (which)
      0: flashRead = 1'b1;
      1: excEntry = 1'b1;
      2: sleepEntry = 1'b1;
      default: dmaGrant = 1'b1;
    endcase
    @(negedge clk);
    flashRead = 1'b0; excEntry = 1'b0; sleepEntry = 1'b0; dmaGrant = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 progActive", progActive, 0);
    chk("R1 eraseActive", eraseActive, 0);
    chk("R1 mask", eraseMask, 0);
    chk("R1 errFlag", errFlag, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reg read", d, 0);
    end
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    wr(2'd0, 8'h01); rd(2'd0, d); chk("R2 ctrl swe", d, 8'h01);
    wr(2'd2, 8'hA5); rd(2'd2, d); chk("R2 blkLo", d, 8'hA5);
    wr(2'd3, 8'h3C); rd(2'd3, d); chk("R2 blkHi", d, 8'h3C);
    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R2 ctrl unused bits", d, 8'h07);
    rd(2'd1, d); chk("R2 status clear", d, 8'h00);
    chk("R6 both requests prog", progActive, 0);
    chk("R6 both requests erase", eraseActive, 0);
    wr(2'd0, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h00);
  endtask

  task automatic t_program();
    wr(2'd0, 8'h03);
    chk("R3 prog active", progActive, 1);
    chk("R3 erase idle", eraseActive, 0);
    wr(2'd0, 8'h02);
    chk("R4 swe cleared drops prog", progActive, 0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_swprot();
    wr(2'd2, 8'h0F);
    wr(2'd0, 8'h04);
    chk("R4 erase blocked no swe", eraseActive, 0);
    wr(2'd0, 8'h02);
    chk("R4 prog blocked no swe", progActive, 0);
    wr(2'd0, 8'h00); wr(2'd2, 8'h00);
  endtask

  task automatic t_erase();
    wr(2'd0, 8'h05);
    chk("R5 empty blocks no erase", eraseActive, 0);
    chk("R5 empty mask", eraseMask, 0);
    wr(2'd2, 8'h81);
    chk("R5 erase active", eraseActive, 1);
    chk("R5 mask low", eraseMask, 16'h0081);
    wr(2'd3, 8'h40);
    chk("R5 mask both", eraseMask, 16'h4081);
    wr(2'd0, 8'h07);
    chk("R6 both bits no erase", eraseActive, 0);
    chk("R6 both bits no prog", progActive, 0);
    wr(2'd0, 8'h01);
    chk("R5 mask gated", eraseMask, 0);
    wr(2'd0, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h00);
  endtask

  task automatic t_error(input int which, input logic useErase);
    logic [7:0] d;
    if (useErase) begin
      wr(2'd3, 8'h01); wr(2'd0, 8'h05);
      chk("R5 erase start", eraseActive, 1);
    end else begin
      wr(2'd0, 8'h03);
      chk("R3 prog start", progActive, 1);
    end
    fireEvent(which);
    chk("R7 errFlag set", errFlag, 1);
    chk("R7 prog aborted", progActive, 0);
    chk("R7 erase aborted", eraseActive, 0);
    rd(2'd1, d); chk("R7 status bit7", d, 8'h80);
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R9 status write ignored", d, 8'h80);
    wr(2'd0, 8'h03);
    chk("R9 prog stays locked", progActive, 0);
    pulseStandby();
    chk("R10 err cleared", errFlag, 0);
    rd(2'd0, d); chk("R10 ctrl cleared", d, 0);
    rd(2'd3, d); chk("R10 blkHi cleared", d, 0);
  endtask

  task automatic t_idle();
    for (int w = 0; w < 4; w++) begin
      fireEvent(w);
      chk("R8 idle event", errFlag, 0);
    end
    wr(2'd0, 8'h02);
    fireEvent(0);
    chk("R8 event with swe off", errFlag, 0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_standbyWrite();
    logic [7:0] d;
    @(negedge clk);
    standby = 1'b1; wrEn = 1'b1; regAddr = 2'd0; wrData = 8'h03;
    @(negedge clk);
    wrEn = 1'b0; regAddr = 2'd2; wrData = 8'hFF; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; standby = 1'b0;
    #1;
    chk("R10 ignored write prog", progActive, 0);
    rd(2'd0, d); chk("R10 ignored ctrl write", d, 0);
    rd(2'd2, d); chk("R10 ignored blk write", d, 0);
  endtask

  task automatic t_resetMid();
    logic [7:0] d;
    wr(2'd0, 8'h03);
    chk("R3 prog before reset", progActive, 1);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk("R1 reset aborts", progActive, 0);
    @(negedge clk);
    rstN = 1'b1;
    rd(2'd0, d); chk("R1 reset clears ctrl", d, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    t_reset();
    t_regmap();
    t_program();
    t_swprot();
    t_erase();
    t_error(0, 1'b0);
    t_error(1, 1'b1);
    t_error(2, 1'b0);
    t_error(3, 1'b1);
    t_idle();
    t_standbyWrite();
    t_resetMid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule